// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address by walking a two-level page table held in memory, for use when a translation cache misses. A request carries the virtual address, whether the access is a read or a write, whether it comes from user or supervisor mode, and the physical location of the top-level directory. The walker fetches one directory word and then one table word through a simple word-wide memory port. Where needed, it writes a word back to record the accessed and dirty status bits.

When the walk ends, the block returns one of two results for one cycle. On success it gives the physical page number and the effective write and user permissions, which are the AND of both levels. On failure it gives a fault, with the faulting address, the access type, the mode, and whether the cause was a missing entry or a permission violation. Pages are 4 KB. The address splits into a 10-bit directory index (bits 31:22), a 10-bit table index (bits 21:12) and a 12-bit offset.

Top module: `xlate_walker`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle with `busy`, `done`, `fault` and `mem_req` all low. This also applies when reset arrives in the middle of a walk.
- R2: The directory word is read at `dir_base + 4*va[31:22]`. The table word is read at `{directory entry[31:12], va[21:12], 2'b00}`.
- R3: On a successful walk, `res_ppn` equals table entry bits 31:12. `res_writable` is the AND of bit 1 of both entries. `res_user_ok` is the AND of bit 2 of both entries. `fault` is low.
- R4: An entry with bit 0 (present) clear, at either level, ends the walk with `fault`=1 and `fault_prot`=0. No further memory access is made for that walk.
- R5: A user-mode access to an entry whose bit 2 is clear, or a write to an entry whose bit 1 is clear, ends the walk with `fault`=1 and `fault_prot`=1. This applies at either level, and a directory-level violation stops the walk before the table read. Supervisor reads of present entries are always allowed.
- R6: After an entry passes its checks, bit 5 (accessed) is written back with a single word write to the same address, but only if the bit was clear. An entry that faults is never written.
- R7: On a write access, table-entry bit 6 (dirty) is set in the same single write as bit 5, and only if either bit needs to change. Reads never set bit 6, and directory entries never get bit 6.
- R8: On a fault, `fault_va`, `fault_write` and `fault_user` hold the address, access type and mode of the faulting request. `fault` is cleared when the next walk starts.
- R9: Every memory request holds its address, direction and data until a cycle with `mem_rvalid` high. The next request is not issued before then. `start` is ignored while `busy` is high.
- R10: `busy` rises in the cycle after an accepted `start` and stays high through the single cycle in which `done` is high. `done` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| dir_base | input | 32 | Physical byte address of the directory |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a fault |
| fault_prot | output | 1 | Fault cause: 1 = permission, 0 = not present |
| fault_va | output | 32 | Faulting virtual address |
| fault_write | output | 1 | Access type of the faulting request |
| fault_user | output | 1 | Mode of the faulting request |
| res_ppn | output | 20 | Translated physical page number |
| res_writable | output | 1 | Combined write permission |
| res_user_ok | output | 1 | Combined user permission |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | 1 = word write, 0 = word read |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Response strobe that completes the request |
| mem_rdata | input | 32 | Read data, valid with `mem_rvalid` |

## Verification
The properties rely on the memory answering only while `mem_req` is high, with one `mem_rvalid` pulse per request, and on `mem_rdata` being meaningful only in that pulse cycle. The bench's memory model drives the response on the falling edge. It raises `mem_rvalid` only for an outstanding request, after a programmable wait, and drops it the following cycle, so no stray or doubled response ever reaches the walker. Stimulus drives `start` away from the active edge. It also includes presses of `start` during a walk, which the walker must ignore.

// File: rtl/xlate_pkg.sv
`timescale 1ns/1ps
// Package: shared entry bit positions and walker state encoding.
// Assumes 32-bit entries laid out identically at both table levels.
package xlate_pkg;
    localparam int BIT_P  = 0;   // present
    localparam int BIT_RW = 1;   // writable
    localparam int BIT_US = 2;   // user accessible
    localparam int BIT_A  = 5;   // accessed
    localparam int BIT_D  = 6;   // dirty (leaf level only)

    typedef enum logic [2:0] {
        W_IDLE,
        W_DIR_RD,
        W_DIR_WB,
        W_TBL_RD,
        W_TBL_WB,
        W_DONE
    } walk_state_e;
endpackage

// File: rtl/walk_addr_gen.sv
`timescale 1ns/1ps
// Module: walk_addr_gen
// Forms the byte addresses of the directory word and the table word.
// Assumes one table fills exactly one page (OFF_W == IDX_W + 2) and 4-byte entries.
module walk_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10
) (
    input  logic [ADDR_W-1:0]       base,
    input  logic [ADDR_W-OFF_W-1:0] vpn,
    input  logic [ADDR_W-OFF_W-1:0] tbl_frame,
    output logic [ADDR_W-1:0]       dir_addr,
    output logic [ADDR_W-1:0]       tbl_addr
);
    localparam int PAD_W = ADDR_W - IDX_W - 2;

    logic [IDX_W-1:0] idx_hi;
    logic [IDX_W-1:0] idx_lo;

    // Split the virtual page number into the two table indices.
    assign idx_hi = vpn[ADDR_W-OFF_W-1 -: IDX_W];
    assign idx_lo = vpn[IDX_W-1:0];

    // Directory word: base plus index scaled by the entry size.
    assign dir_addr = base + {{PAD_W{1'b0}}, idx_hi, 2'b00};

    // Table word: table frame concatenated with scaled second index.
    assign tbl_addr = {tbl_frame, idx_lo, 2'b00};
endmodule

// File: rtl/walk_entry_check.sv
`timescale 1ns/1ps
// Module: walk_entry_check
// Decodes one page-table word: presence, permission for the access, and
// whether status bits must be written back (and the word to write).
// LEAF selects whether the dirty bit is maintained at this level.
module walk_entry_check
    import xlate_pkg::*;
#(
    parameter int ENT_W = 32,
    parameter bit LEAF  = 1'b0
) (
    input  logic [ENT_W-1:0] entry,
    input  logic             acc_write,
    input  logic             acc_user,
    output logic             present,
    output logic             allowed,
    output logic             wb_needed,
    output logic [ENT_W-1:0] wb_word
);
    logic [ENT_W-1:0] set_mask;

    // Pick the status bits this level must carry after a legal access.
    generate
        if (LEAF) begin : g_leaf
            always_comb begin
                set_mask         = '0;
                set_mask[BIT_A]  = 1'b1;
                set_mask[BIT_D]  = acc_write;
            end
        end else begin : g_dir
            always_comb begin
                set_mask         = '0;
                set_mask[BIT_A]  = 1'b1;
            end
        end
    endgenerate

    // Presence and permission decode for the requested access.
    always_comb begin
        present = entry[BIT_P];
        allowed = !(acc_user && !entry[BIT_US]) && !(acc_write && !entry[BIT_RW]);
    end

    // Write back only when some required bit is still clear.
    always_comb begin
        wb_word   = entry | set_mask;
        wb_needed = |(set_mask & ~entry);
    end
endmodule

// File: rtl/xlate_walker.sv
`timescale 1ns/1ps
// Module: xlate_walker (top)
// Walks a two-level page table over a single-outstanding word memory port:
// directory read, optional status write-back, table read, optional write-back.
// Assumes the memory answers each request with exactly one mem_rvalid pulse.
module xlate_walker
    import xlate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [ADDR_W-1:0]       req_va,
    input  logic                    req_write,
    input  logic                    req_user,
    input  logic [ADDR_W-1:0]       dir_base,
    output logic                    busy,
    output logic                    done,
    output logic                    fault,
    output logic                    fault_prot,
    output logic [ADDR_W-1:0]       fault_va,
    output logic                    fault_write,
    output logic                    fault_user,
    output logic [ADDR_W-OFF_W-1:0] res_ppn,
    output logic                    res_writable,
    output logic                    res_user_ok,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [ADDR_W-1:0]       mem_wdata,
    input  logic                    mem_rvalid,
    input  logic [ADDR_W-1:0]       mem_rdata
);
    localparam int PPN_W = ADDR_W - OFF_W;

    walk_state_e       st;
    logic [ADDR_W-1:0] va_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] wb_q;
    logic              wr_q;
    logic              usr_q;
    logic [PPN_W-1:0]  pde_frame_q;
    logic              pde_rw_q;
    logic              pde_us_q;

    logic [ADDR_W-1:0] dir_addr;
    logic [ADDR_W-1:0] tbl_addr;

    logic              d_present, d_allowed, d_wb_needed;
    logic              t_present, t_allowed, t_wb_needed;
    logic [ADDR_W-1:0] d_wb_word;
    logic [ADDR_W-1:0] t_wb_word;

    // Address formation for both levels.
    walk_addr_gen #(
        .ADDR_W(ADDR_W),
        .OFF_W (OFF_W),
        .IDX_W (IDX_W)
    ) u_addr (
        .base     (base_q),
        .vpn      (va_q[ADDR_W-1:OFF_W]),
        .tbl_frame(pde_frame_q),
        .dir_addr (dir_addr),
        .tbl_addr (tbl_addr)
    );

    // Directory-level decode of the returned word.
    walk_entry_check #(
        .ENT_W(ADDR_W),
        .LEAF (1'b0)
    ) u_dir_chk (
        .entry    (mem_rdata),
        .acc_write(wr_q),
        .acc_user (usr_q),
        .present  (d_present),
        .allowed  (d_allowed),
        .wb_needed(d_wb_needed),
        .wb_word  (d_wb_word)
    );

    // Table-level decode of the returned word.
    walk_entry_check #(
        .ENT_W(ADDR_W),
        .LEAF (1'b1)
    ) u_tbl_chk (
        .entry    (mem_rdata),
        .acc_write(wr_q),
        .acc_user (usr_q),
        .present  (t_present),
        .allowed  (t_allowed),
        .wb_needed(t_wb_needed),
        .wb_word  (t_wb_word)
    );

    // Walk sequencer: request capture, level steps, fault and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= W_IDLE;
            va_q         <= '0;
            base_q       <= '0;
            wb_q         <= '0;
            wr_q         <= 1'b0;
            usr_q        <= 1'b0;
            pde_frame_q  <= '0;
            pde_rw_q     <= 1'b0;
            pde_us_q     <= 1'b0;
            fault        <= 1'b0;
            fault_prot   <= 1'b0;
            fault_va     <= '0;
            fault_write  <= 1'b0;
            fault_user   <= 1'b0;
            res_ppn      <= '0;
            res_writable <= 1'b0;
            res_user_ok  <= 1'b0;
        end else begin
            case (st)
                W_IDLE: begin
                    if (start) begin
                        va_q         <= req_va;
                        base_q       <= dir_base;
                        wr_q         <= req_write;
                        usr_q        <= req_user;
                        fault        <= 1'b0;
                        fault_prot   <= 1'b0;
                        res_ppn      <= '0;
                        res_writable <= 1'b0;
                        res_user_ok  <= 1'b0;
                        st           <= W_DIR_RD;
                    end
                end
                W_DIR_RD: begin
                    if (mem_rvalid) begin
                        pde_frame_q <= mem_rdata[ADDR_W-1:OFF_W];
                        pde_rw_q    <= mem_rdata[BIT_RW];
                        pde_us_q    <= mem_rdata[BIT_US];
                        wb_q        <= d_wb_word;
                        if (!d_present || !d_allowed) begin
                            fault       <= 1'b1;
                            fault_prot  <= d_present;
                            fault_va    <= va_q;
                            fault_write <= wr_q;
                            fault_user  <= usr_q;
                            st          <= W_DONE;
                        end else if (d_wb_needed) begin
                            st <= W_DIR_WB;
                        end else begin
                            st <= W_TBL_RD;
                        end
                    end
                end
                W_DIR_WB: begin
                    if (mem_rvalid) begin
                        st <= W_TBL_RD;
                    end
                end
                W_TBL_RD: begin
                    if (mem_rvalid) begin
                        wb_q <= t_wb_word;
                        if (!t_present || !t_allowed) begin
                            fault       <= 1'b1;
                            fault_prot  <= t_present;
                            fault_va    <= va_q;
                            fault_write <= wr_q;
                            fault_user  <= usr_q;
                            st          <= W_DONE;
                        end else begin
                            res_ppn      <= mem_rdata[ADDR_W-1:OFF_W];
                            res_writable <= pde_rw_q & mem_rdata[BIT_RW];
                            res_user_ok  <= pde_us_q & mem_rdata[BIT_US];
                            st           <= t_wb_needed ? W_TBL_WB : W_DONE;
                        end
                    end
                end
                W_TBL_WB: begin
                    if (mem_rvalid) begin
                        st <= W_DONE;
                    end
                end
                W_DONE: begin
                    st <= W_IDLE;
                end
                default: begin
                    st <= W_IDLE;
                end
            endcase
        end
    end

    // Memory port drive, selected by the current walk step.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = wb_q;
        case (st)
            W_DIR_RD: begin mem_req = 1'b1; mem_addr = dir_addr; end
            W_DIR_WB: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = dir_addr; end
            W_TBL_RD: begin mem_req = 1'b1; mem_addr = tbl_addr; end
            W_TBL_WB: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = tbl_addr; end
            default:  begin mem_req = 1'b0; end
        endcase
    end

    // Handshake status outputs.
    assign busy = (st != W_IDLE);
    assign done = (st == W_DONE);
endmodule

// File: rtl/xlate_walker_chk.sv
`timescale 1ns/1ps
// Module: xlate_walker_chk
// Port-level temporal checks for xlate_walker, attached with bind.
// Assumes mem_rvalid pulses only for an outstanding request.
module xlate_walker_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic              rd_present,
    input logic              wr_acc
);
    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R4
    absent_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rvalid && !mem_we && !rd_present) |=> !mem_req);

    // R6
    wb_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> wr_acc);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R10
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

bind xlate_walker xlate_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_rvalid(mem_rvalid),
    .rd_present(mem_rdata[0]),
    .wr_acc    (mem_wdata[5])
);

// File: tb/xlate_walker_tb.sv
`timescale 1ns/1ps
// Bench for xlate_walker: vector table walk plus directed corner tests.
module xlate_walker_tb;
    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic        usr;
        logic [31:0] pde;
        logic [31:0] pte;
        logic [1:0]  kind;   // 0 ok, 1 not present, 2 protection
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'h0040_3ABC, 1'b0, 1'b0, 32'h0000_1007, 32'h0ABC_D007, 2'd0},
        '{32'h0080_5123, 1'b1, 1'b1, 32'h0000_1027, 32'h1234_5027, 2'd0},
        '{32'h0080_5123, 1'b1, 1'b1, 32'h0000_1027, 32'h1234_5067, 2'd0},
        '{32'h00C0_0000, 1'b0, 1'b0, 32'h0000_1006, 32'h0000_0000, 2'd1},
        '{32'h0040_7000, 1'b0, 1'b0, 32'h0000_2027, 32'h0000_0026, 2'd1},
        '{32'h0040_3000, 1'b0, 1'b1, 32'h0000_1023, 32'hFFFF_F027, 2'd2},
        '{32'h0040_3000, 1'b1, 1'b0, 32'h0000_1025, 32'hFFFF_F027, 2'd2},
        '{32'h0100_9FFF, 1'b1, 1'b1, 32'h0000_2027, 32'h5555_5025, 2'd2},
        '{32'h0100_9FFF, 1'b0, 1'b1, 32'h0000_2027, 32'h5555_5023, 2'd2},
        '{32'hFFFF_F004, 1'b0, 1'b0, 32'h0000_3021, 32'h7777_7001, 2'd0},
        '{32'h0040_3010, 1'b0, 1'b1, 32'h0000_1027, 32'h0000_F027, 2'd0},
        '{32'h0040_3000, 1'b1, 1'b0, 32'h0000_1005, 32'h0000_0000, 2'd2},
        '{32'h0040_3000, 1'b1, 1'b0, 32'h0000_1003, 32'h0BAD_0003, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] req_va = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] dir_base = '0;
    logic        busy, done, fault, fault_prot, fault_write, fault_user;
    logic [31:0] fault_va;
    logic [19:0] res_ppn;
    logic        res_writable, res_user_ok;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [0:4095];
    int          lat = 0;
    int          wcnt = 0;
    int          nreads = 0;
    int          nwrites = 0;
    logic [31:0] rd_log [0:3];
    int          checks = 0;
    int          fails = 0;

    always #2.5 clk = ~clk;

    xlate_walker u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_va(req_va),
        .req_write(req_write), .req_user(req_user), .dir_base(dir_base),
        .busy(busy), .done(done), .fault(fault), .fault_prot(fault_prot),
        .fault_va(fault_va), .fault_write(fault_write), .fault_user(fault_user),
        .res_ppn(res_ppn), .res_writable(res_writable), .res_user_ok(res_user_ok),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // Memory model: answers on the falling edge after lat idle cycles.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rvalid = 1'b0;
            wcnt = 0;
        end else if (mem_rvalid) begin
            mem_rvalid = 1'b0;
            wcnt = 0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                mem_rvalid = 1'b1;
                if (mem_we) begin
                    mem[mem_addr[13:2]] = mem_wdata;
                    nwrites++;
                end else begin
                    mem_rdata = mem[mem_addr[13:2]];
                    if (nreads < 4) rd_log[nreads] = mem_addr;
                    nreads++;
                end
            end else begin
                wcnt++;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Launch one walk and wait for done; busy seen after the first edge is returned.
    task automatic run_walk(input logic [31:0] va, input logic wr, input logic usr,
                            output logic busy_after, output bit timed_out);
        @(negedge clk);
        nreads = 0;
        nwrites = 0;
        req_va = va;
        req_write = wr;
        req_user = usr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        busy_after = busy;
        timed_out = 1'b1;
        for (int k = 0; k < 300; k++) begin
            if (done) begin
                timed_out = 1'b0;
                break;
            end
            @(negedge clk);
        end
        if (timed_out) begin
            checks++;
            fails++;
            $display("FAIL R10 walk timeout actual=%h expected=%h", 32'h0, 32'h1);
        end
    endtask

    // Global watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R10 actual=%h expected=%h", 32'h0, 32'h1);
        summary();
        $finish;
    end

    initial begin
        logic busy_after;
        bit   to;
        for (int a = 0; a < 4096; a++) mem[a] = '0;
        for (int a = 0; a < 4; a++) rd_log[a] = '0;

        // Reset state (R1).
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", {31'b0, busy}, 32'h0);
        chk("R1", "done in reset", {31'b0, done}, 32'h0);
        chk("R1", "mem_req in reset", {31'b0, mem_req}, 32'h0);
        chk("R1", "fault in reset", {31'b0, fault}, 32'h0);
        rst_n = 1'b1;

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [31:0] pde_a, pte_a, pde_x, pte_x;
            logic        dir_pass;
            int          exp_rd, exp_wr;
            v = VECS[i];
            lat = i % 3;
            dir_base = '0;
            pde_a = {20'h0, v.va[31:22], 2'b00};
            pte_a = {v.pde[31:12], v.va[21:12], 2'b00};
            mem[pde_a[13:2]] = v.pde;
            mem[pte_a[13:2]] = v.pte;
            dir_pass = v.pde[0] && !(v.usr && !v.pde[2]) && !(v.wr && !v.pde[1]);
            pde_x = dir_pass ? (v.pde | 32'h20) : v.pde;
            pte_x = (v.kind == 2'd0) ? (v.pte | 32'h20 | (v.wr ? 32'h40 : 32'h0)) : v.pte;
            exp_rd = dir_pass ? 2 : 1;
            exp_wr = ((pde_x != v.pde) ? 1 : 0) + ((pte_x != v.pte) ? 1 : 0);

            run_walk(v.va, v.wr, v.usr, busy_after, to);
            chk("R10", "busy after start", {31'b0, busy_after}, 32'h1);
            chk("R2", "directory address", rd_log[0], pde_a);
            if (dir_pass) chk("R2", "table address", rd_log[1], pte_a);
            chk("R4", "read count", nreads, exp_rd);
            chk("R6", "write count", nwrites, exp_wr);
            chk("R6", "directory word after", mem[pde_a[13:2]], pde_x);
            if (dir_pass) chk("R7", "table word after", mem[pte_a[13:2]], pte_x);
            chk("R8", "fault flag", {31'b0, fault}, {31'b0, v.kind != 2'd0});
            if (v.kind == 2'd0) begin
                chk("R3", "ppn", {12'h0, res_ppn}, {12'h0, v.pte[31:12]});
                chk("R3", "writable", {31'b0, res_writable}, {31'b0, v.pde[1] & v.pte[1]});
                chk("R3", "user ok", {31'b0, res_user_ok}, {31'b0, v.pde[2] & v.pte[2]});
            end else begin
                chk(v.kind == 2'd2 ? "R5" : "R4", "fault cause", {31'b0, fault_prot},
                    {31'b0, v.kind == 2'd2});
                chk("R8", "fault va", fault_va, v.va);
                chk("R8", "fault write", {31'b0, fault_write}, {31'b0, v.wr});
                chk("R8", "fault user", {31'b0, fault_user}, {31'b0, v.usr});
            end
            @(negedge clk);
            chk("R10", "done single cycle", {31'b0, done}, 32'h0);
            chk("R10", "idle after done", {31'b0, busy}, 32'h0);
        end

        // Directed: start during a walk is ignored (R9).
        lat = 3;
        dir_base = '0;
        mem[1] = 32'h0000_1027;
        mem[32'h100C >> 2] = 32'h0ABC_D027;
        @(negedge clk);
        nreads = 0;
        nwrites = 0;
        req_va = 32'h0040_3000; req_write = 1'b0; req_user = 1'b0; start = 1'b1;
        @(negedge clk);
        req_va = 32'h00C0_0000; req_write = 1'b1; req_user = 1'b1;
        for (int k = 0; k < 300; k++) begin
            if (done) break;
            @(negedge clk);
        end
        start = 1'b0;
        chk("R9", "ppn with start held", {12'h0, res_ppn}, 32'h0000_ABCD);
        chk("R9", "no fault with start held", {31'b0, fault}, 32'h0);
        chk("R9", "reads with start held", nreads, 2);
        chk("R9", "writes with start held", nwrites, 0);
        @(negedge clk);
        @(negedge clk);

        // Directed: non-zero directory base (R2).
        lat = 1;
        dir_base = 32'h0000_0800;
        mem[32'h0808 >> 2] = 32'h0000_3027;
        mem[32'h3008 >> 2] = 32'h0000_4027;
        run_walk(32'h0080_2000, 1'b0, 1'b0, busy_after, to);
        chk("R2", "based directory address", rd_log[0], 32'h0000_0808);
        chk("R2", "based table address", rd_log[1], 32'h0000_3008);
        chk("R3", "based ppn", {12'h0, res_ppn}, 32'h0000_0004);

        // Directed: reset in the middle of a walk (R1).
        lat = 6;
        @(negedge clk);
        req_va = 32'h0040_3000; req_write = 1'b0; req_user = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "busy after mid-walk reset", {31'b0, busy}, 32'h0);
        chk("R1", "mem_req after mid-walk reset", {31'b0, mem_req}, 32'h0);
        chk("R1", "done after mid-walk reset", {31'b0, done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        summary();
        $finish;
    end
endmodule